// File: doc/BRIEF.md
# External Bus Strobe Timing Generator

This block produces the address-latch and program-store strobes for an 8051-style core whose machine cycle is twelve oscillator clocks long. It also decides, once per machine cycle, whether the instruction fetch is served by on-chip program memory or by the external bus, and which source drives the upper address byte on the high port.

A free-running state counter divides each machine cycle into six states of two clocks. The address-latch strobe is high for the first and fourth state, so it pulses twice per machine cycle. The program-store strobe is active low and asserts in the two states after each address-latch pulse, but only when the cycle fetches from outside. The core flags each machine cycle that carries an external data access, and gives the width of its address. In such a cycle the first address-latch pulse and both program-store pulses are withheld. The flags, the external-access pin and the program counter are captured during the first clock of each machine cycle and held until the next one begins.

Top module: `bus_strobe_gen`

## Requirements
- R1: A machine cycle is 12 clocks, made of six states (S1..S6) of 2 clocks each, with S1 beginning on the first clock after reset release. In a cycle without a data access, `ale` is high for both clocks of S1 and S4 and low in every other state.
- R2: While `rst_n` is low, `ale` is 1 and `psen_n` is 1. The first clock after release is the first clock of S1.
- R3: In a cycle with `xdata_cyc` = 1, `ale` stays low during S1 and is still high during S4, so exactly one pulse is withheld.
- R4: In a cycle that fetches externally and has no data access, `psen_n` is 0 during S2, S3, S5 and S6 and 1 during S1 and S4.
- R5: `psen_n` stays 1 for the whole cycle when the fetch is internal or when `xdata_cyc` = 1.
- R6: When `rom_en` = 0, `fetch_ext` = 1 for every program counter value, including 0x0000 to 0x0FFF.
- R7: When `rom_en` = 1, `fetch_ext` = 1 exactly when `pc` is 0x1000 or above. The value 0x0FFF gives 0.
- R8: `hi_sel` encodes the high-port source: 0 is the port latch, 1 is the PC upper byte, 2 is the data-pointer upper byte. In a data cycle it is 2 if `xdata_wide` = 1 and 0 otherwise. In any other cycle it is 1 if `fetch_ext` = 1 and 0 otherwise.
- R9: `rom_en`, `pc`, `xdata_cyc` and `xdata_wide` are taken during the first clock of S1. Changing them later in the cycle has no effect on any output until the next S1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rom_en | input | 1 | External-access pin: 1 allows on-chip program memory |
| pc | input | 16 | Program counter for this cycle's fetch |
| xdata_cyc | input | 1 | This machine cycle carries an external data access |
| xdata_wide | input | 1 | The data access uses a 16-bit address |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| fetch_ext | output | 1 | 1 when this cycle's fetch uses the external bus |
| hi_sel | output | 2 | High-port upper-address source (encoding in R8) |

## Verification
The assertions assume that the inputs change only at clock edges and that reset is held for at least one clock edge. They also assume that whatever the inputs are during the first clock of S1 is what the core intends for that cycle. The bench drives new cycle inputs just after the edge that opens S1. Halfway through each cycle it scrambles the inputs at random, so that the hold behaviour is exercised without breaking those assumptions. A reset in the middle of the run checks that the state sequence restarts cleanly.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

  typedef enum logic [1:0] {
    HI_PORT_LATCH = 2'd0,
    HI_PC_UPPER   = 2'd1,
    HI_DPTR_UPPER = 2'd2
  } hi_src_e;

  // External fetch when the pin forbids on-chip code or the address lies past it.
  function automatic logic pick_external(input logic rom_allowed,
                                         input logic [31:0] pc_val,
                                         input logic [31:0] rom_depth);
    return !rom_allowed || (pc_val >= rom_depth);
  endfunction

  function automatic hi_src_e pick_hi_src(input logic data_cyc,
                                          input logic wide,
                                          input logic ext);
    if (data_cyc) return wide ? HI_DPTR_UPPER : HI_PORT_LATCH;
    return ext ? HI_PC_UPPER : HI_PORT_LATCH;
  endfunction

endpackage

// File: rtl/strobe_state_ctr.sv
module strobe_state_ctr #(
  parameter int STATES         = 6,
  parameter int CLKS_PER_STATE = 2,
  localparam int ST_W = (STATES > 1) ? $clog2(STATES) : 1,
  localparam int PH_W = (CLKS_PER_STATE > 1) ? $clog2(CLKS_PER_STATE) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [ST_W-1:0] st,
  output logic [PH_W-1:0] ph,
  output logic            cyc_start
);
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(STATES - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLKS_PER_STATE - 1);

  logic [ST_W-1:0] st_q;
  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      ph_q <= '0;
    end else if (ph_q == PH_LAST) begin
      ph_q <= '0;
      st_q <= (st_q == ST_LAST) ? '0 : st_q + 1'b1;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign st        = st_q;
  assign ph        = ph_q;
  assign cyc_start = (st_q == '0) && (ph_q == '0);
endmodule

// File: rtl/cycle_sampler.sv
module cycle_sampler #(
  parameter int PC_W      = 16,
  parameter int ROM_DEPTH = 4096
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_start,
  input  logic            rom_en,
  input  logic [PC_W-1:0] pc,
  input  logic            xdata_cyc,
  input  logic            xdata_wide,
  output logic            xd_cur,
  output logic            wide_cur,
  output logic            ext_cur
);
  import bus_strobe_pkg::*;

  logic xd_live, wide_live, ext_live;
  logic xd_q, wide_q, ext_q;

  assign xd_live   = xdata_cyc & rst_n;
  assign wide_live = xdata_wide & rst_n;
  assign ext_live  = rst_n & pick_external(rom_en, 32'(pc), 32'(ROM_DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xd_q   <= 1'b0;
      wide_q <= 1'b0;
      ext_q  <= 1'b0;
    end else if (cyc_start) begin
      xd_q   <= xd_live;
      wide_q <= wide_live;
      ext_q  <= ext_live;
    end
  end

  // Live during the opening clock, held for the rest of the cycle.
  assign xd_cur   = cyc_start ? xd_live   : xd_q;
  assign wide_cur = cyc_start ? wide_live : wide_q;
  assign ext_cur  = cyc_start ? ext_live  : ext_q;
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode #(
  parameter int STATES = 6,
  localparam int ST_W = (STATES > 1) ? $clog2(STATES) : 1
) (
  input  logic            [ST_W-1:0] st,
  input  logic                       xd_cur,
  input  logic                       wide_cur,
  input  logic                       ext_cur,
  output logic                       ale,
  output logic                       psen_n,
  output logic                       fetch_ext,
  output bus_strobe_pkg::hi_src_e    hi_sel
);
  import bus_strobe_pkg::*;

  localparam logic [ST_W-1:0] ST_FIRST = '0;
  localparam logic [ST_W-1:0] ST_MID   = ST_W'(STATES / 2);

  logic at_first, at_mid;
  assign at_first = (st == ST_FIRST);
  assign at_mid   = (st == ST_MID);

  assign ale       = (at_first && !xd_cur) || at_mid;
  assign psen_n    = !(ext_cur && !xd_cur && !at_first && !at_mid);
  assign fetch_ext = ext_cur;
  assign hi_sel    = pick_hi_src(xd_cur, wide_cur, ext_cur);
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen #(
  parameter int STATES         = 6,
  parameter int CLKS_PER_STATE = 2,
  parameter int PC_W           = 16,
  parameter int ROM_DEPTH      = 4096
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rom_en,
  input  logic [PC_W-1:0] pc,
  input  logic            xdata_cyc,
  input  logic            xdata_wide,
  output logic            ale,
  output logic            psen_n,
  output logic            fetch_ext,
  output logic [1:0]      hi_sel
);
  import bus_strobe_pkg::*;

  localparam int ST_W = (STATES > 1) ? $clog2(STATES) : 1;
  localparam int PH_W = (CLKS_PER_STATE > 1) ? $clog2(CLKS_PER_STATE) : 1;

  // Named internal events, visible to the bound checker.
  logic [ST_W-1:0] st;
  logic [PH_W-1:0] ph;
  logic            cyc_start;
  logic            xd_cur, wide_cur, ext_cur;
  hi_src_e         hi_src;

  strobe_state_ctr #(.STATES(STATES), .CLKS_PER_STATE(CLKS_PER_STATE)) u_ctr (
    .clk(clk), .rst_n(rst_n), .st(st), .ph(ph), .cyc_start(cyc_start)
  );

  cycle_sampler #(.PC_W(PC_W), .ROM_DEPTH(ROM_DEPTH)) u_smp (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .rom_en(rom_en), .pc(pc), .xdata_cyc(xdata_cyc), .xdata_wide(xdata_wide),
    .xd_cur(xd_cur), .wide_cur(wide_cur), .ext_cur(ext_cur)
  );

  strobe_decode #(.STATES(STATES)) u_dec (
    .st(st), .xd_cur(xd_cur), .wide_cur(wide_cur), .ext_cur(ext_cur),
    .ale(ale), .psen_n(psen_n), .fetch_ext(fetch_ext), .hi_sel(hi_src)
  );

  assign hi_sel = hi_src;
endmodule

// File: rtl/bus_strobe_gen_sva.sv
module bus_strobe_gen_sva #(
  parameter int STATES = 6,
  parameter int CLKS_PER_STATE = 2,
  localparam int ST_W = (STATES > 1) ? $clog2(STATES) : 1,
  localparam int PH_W = (CLKS_PER_STATE > 1) ? $clog2(CLKS_PER_STATE) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [ST_W-1:0] st,
  input logic [PH_W-1:0] ph,
  input logic            xd_cur,
  input logic            ale,
  input logic            psen_n,
  input logic            fetch_ext,
  input logic [1:0]      hi_sel
);
  localparam logic [ST_W-1:0] ST_MID  = ST_W'(STATES / 2);
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(STATES - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLKS_PER_STATE - 1);

  p_reset_strobes_r2: assert property (@(posedge clk) !rst_n |-> (ale && psen_n));

  p_wrap_to_s1_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LAST && ph == PH_LAST) |=> (st == '0 && ph == '0));

  p_ale_mid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MID) |-> ale);

  p_ale_withheld_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == '0 && xd_cur) |-> !ale);

  p_psen_ale_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && !psen_n));

  p_psen_needs_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> (fetch_ext && !xd_cur));

  p_hi_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_sel != 2'd3);

  p_hold_in_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != '0) |-> ($stable(fetch_ext) && $stable(hi_sel)));
endmodule

bind bus_strobe_gen bus_strobe_gen_sva #(.STATES(STATES), .CLKS_PER_STATE(CLKS_PER_STATE)) u_sva (
  .clk(clk), .rst_n(rst_n), .st(st), .ph(ph), .xd_cur(xd_cur),
  .ale(ale), .psen_n(psen_n), .fetch_ext(fetch_ext), .hi_sel(hi_sel)
);

// File: tb/bus_strobe_gen_bench.sv
`timescale 1ns/1ps
module bus_strobe_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rom_en = 1'b1;
  logic [15:0] pc = '0;
  logic        xdata_cyc = 1'b0;
  logic        xdata_wide = 1'b0;
  logic        ale, psen_n, fetch_ext;
  logic [1:0]  hi_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int pos    = 0;

  // values the current machine cycle was opened with
  logic        c_rom, c_xd, c_wide;
  logic [15:0] c_pc;

  always #2 clk = ~clk;

  bus_strobe_gen u_bus_strobe_gen (
    .clk(clk), .rst_n(rst_n), .rom_en(rom_en), .pc(pc),
    .xdata_cyc(xdata_cyc), .xdata_wide(xdata_wide),
    .ale(ale), .psen_n(psen_n), .fetch_ext(fetch_ext), .hi_sel(hi_sel)
  );

  function automatic bit m_ext(input bit rom, input logic [15:0] a);
    if (!rom) return 1'b1;
    return a > 16'h0FFF;
  endfunction

  function automatic bit m_ale(input int p, input bit xd);
    int s = p / 2;
    if (s == 3) return 1'b1;
    if (s == 0) return !xd;
    return 1'b0;
  endfunction

  function automatic bit m_psen_n(input int p, input bit xd, input bit ext);
    int s = p / 2;
    if (xd || !ext) return 1'b1;
    return (s == 0) || (s == 3);
  endfunction

  function automatic logic [1:0] m_hi(input bit xd, input bit wide, input bit ext);
    if (xd) return wide ? 2'd2 : 2'd0;
    return ext ? 2'd1 : 2'd0;
  endfunction

  task automatic check(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s pos=%0d actual=%0d expected=%0d", tag, what, pos, act, exp);
    end
  endtask

  task automatic drive(input bit rom, input logic [15:0] a, input bit xd, input bit wide);
    rom_en = rom; pc = a; xdata_cyc = xd; xdata_wide = wide;
    c_rom = rom; c_pc = a; c_xd = xd; c_wide = wide;
  endtask

  task automatic drive_random();
    logic [15:0] a;
    case ($urandom % 4)
      0: a = 16'h0FFF;
      1: a = 16'h1000;
      default: a = 16'($urandom);
    endcase
    drive(1'($urandom % 4 != 0), a, 1'($urandom % 3 == 0), 1'($urandom));
  endtask

  task automatic check_now();
    bit ext = m_ext(c_rom, c_pc);
    bit exp_p = m_psen_n(pos, c_xd, ext);
    check(c_xd ? "R3" : "R1", "ale", {1'b0, ale}, {1'b0, m_ale(pos, c_xd)});
    check(exp_p ? "R5" : "R4", "psen_n", {1'b0, psen_n}, {1'b0, exp_p});
    check(pos >= 6 ? "R9" : (c_rom ? "R7" : "R6"), "fetch_ext", {1'b0, fetch_ext}, {1'b0, ext});
    check("R8", "hi_sel", hi_sel, m_hi(c_xd, c_wide, ext));
  endtask

  // one machine cycle; drive_cycle: 0 random, 1 already driven
  task automatic run_cycle(input bit preset);
    for (int k = 0; k < 12; k++) begin
      if (k == 0 && !preset) begin
        @(posedge clk); #1; pos = 0; drive_random();
      end else if (k != 0) begin
        @(posedge clk); #1; pos = k;
        if (k == 6) begin // mid-cycle scramble must be ignored (R9)
          rom_en = 1'($urandom); pc = 16'($urandom);
          xdata_cyc = 1'($urandom); xdata_wide = 1'($urandom);
        end
      end
      @(negedge clk); #0.5;
      check_now();
    end
  endtask

  task automatic reset_phase(input int n, input bit rom, input logic [15:0] a, input bit xd, input bit wide);
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #0.5;
      check("R2", "ale in reset", {1'b0, ale}, 2'd1);
      check("R2", "psen_n in reset", {1'b0, psen_n}, 2'd1);
    end
    drive(rom, a, xd, wide);
    @(negedge clk); rst_n = 1'b1; pos = 0;
    #0.5; check_now(); // first clock of S1 (R2)
    for (int k = 1; k < 12; k++) begin
      @(posedge clk); #1; pos = k;
      @(negedge clk); #0.5;
      check_now();
    end
  endtask

  task automatic directed(input bit rom, input logic [15:0] a, input bit xd, input bit wide);
    @(posedge clk); #1; pos = 0; drive(rom, a, xd, wide);
    @(negedge clk); #0.5; check_now();
    for (int k = 1; k < 12; k++) begin
      @(posedge clk); #1; pos = k;
      @(negedge clk); #0.5; check_now();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    reset_phase(4, 1'b0, 16'h0000, 1'b0, 1'b0);   // R2, R6 external fetch at 0
    directed(1'b1, 16'h0FFF, 1'b0, 1'b0);         // R7 last internal address
    directed(1'b1, 16'h1000, 1'b0, 1'b0);         // R7 first external address, R4
    directed(1'b0, 16'h0FFF, 1'b0, 1'b0);         // R6
    directed(1'b1, 16'h2000, 1'b1, 1'b1);         // R3 wide data access, R8
    directed(1'b1, 16'h0100, 1'b1, 1'b0);         // R3 narrow data access, R8
    directed(1'b0, 16'hFFFF, 1'b1, 1'b0);         // R5 data cycle blocks psen
    for (int i = 0; i < 120; i++) run_cycle(1'b0);
    reset_phase(3, 1'b1, 16'h1234, 1'b1, 1'b1);   // R2 mid-run restart
    for (int i = 0; i < 120; i++) run_cycle(1'b0);
    finish_run();
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule